// File: doc/BRIEF.md
# Per-Function Queue Configuration Registers

This block holds the configuration of a set of device queues for several virtual functions. It sits behind a memory-mapped request interface. Each function has its own queue selector register. A window of per-queue registers then shows the descriptor address, the available-ring address, the queue size and the enable bit of the queue that function has selected.

One write request can carry a selector value and a field value together. In that case the selector is stored and the field is written into the queue that this same selector names, in one cycle. A write that carries only the selector stores the index and leaves every queue untouched. A later read from the same function returns the field of the latched queue. Because each function keeps its own selector, traffic from other functions between one function's select and its read has no effect on what that read returns.

Requests are accepted one per cycle and take effect in arrival order. A read places its data in a single response register. While that response waits for the consumer, the request side is stalled.

Top module: `vq_cfg_regs`

## Requirements
- R1: After reset, every function's selector reads 0, and every queue's address halves and enable read 0. Every queue's size reads QMAX (256 by default). rsp_valid is low and req_ready is high.
- R2: A write with req_sel_en=1 and req_fld_en=1 stores req_sel as that function's selector. In the same cycle it writes req_wdata into the field at req_off of the queue numbered req_sel.
- R3: A write with req_sel_en=1 and req_fld_en=0 stores only the selector. It changes no queue field.
- R4: A read returns the field at req_off of the queue named by the most recent selector stored for req_fid. This holds for a read accepted in the cycle right after the selector write.
- R5: Each function's selector is independent. Selector writes from other functions never change it.
- R6: If the effective selector is NQ or higher, field writes are ignored and field reads return 0. Reading word 0 still returns the stored selector.
- R7: Word offsets are: 0 selector, 1 descriptor address low, 2 descriptor address high, 3 ring address low, 4 ring address high, 5 size (data bits 15:0), 6 enable (data bit 0), 7 reserved. Unused read bits are 0. The reserved word reads 0 and ignores writes. A field write to word 0 has no effect.
- R8: When the response slot is free, one request is accepted per cycle. An accepted read drives rsp_valid in the next cycle. An accepted write produces no response.
- R9: While rsp_valid is high and rsp_ready is low, req_ready stays low and rsp_rdata holds its value. Responses come back in request order.
- R10: A read with req_sel_en=1 first stores req_sel as the function's selector. It then returns the field of that queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_fid | input | FID_W (2) | Issuing virtual function |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sel_en | input | 1 | Request carries a selector value |
| req_sel | input | SEL_W (8) | Selector value |
| req_fld_en | input | 1 | Write carries a field value |
| req_off | input | 3 | Word offset of the field |
| req_wdata | input | 32 | Field write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read response data |

## Verification
The bench builds the block with its defaults: four functions, eight queues per function and an 8-bit selector. Selector values 8 to 255 can therefore be written, which exercises the out-of-range path on both reads and writes. The 2-bit function ID reaches every function, so interleaved select-then-read sequences can be checked for isolation. The bench also drives the response-ready line low, randomly and in long holds. This brings the stall path into play with reads queued behind one another, alongside back-to-back accepted requests.

// File: rtl/vq_cfg_pkg.sv
package vq_cfg_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        REG_SEL      = 3'd0,
        REG_DESC_LO  = 3'd1,
        REG_DESC_HI  = 3'd2,
        REG_AVAIL_LO = 3'd3,
        REG_AVAIL_HI = 3'd4,
        REG_SIZE     = 3'd5,
        REG_ENABLE   = 3'd6,
        REG_RSVD     = 3'd7
    } vq_reg_e;

    typedef struct packed {
        logic [63:0] desc;
        logic [63:0] avail;
        logic [15:0] size;
        logic        en;
    } vq_entry_t;

endpackage

// File: rtl/vq_sel_bank.sv
module vq_sel_bank #(
    parameter int NF    = 4,
    parameter int SEL_W = 8,
    parameter int FID_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [FID_W-1:0]           wr_fid,
    input  logic [SEL_W-1:0]           wr_sel,
    output logic [NF-1:0][SEL_W-1:0]   sel_o
);

    typedef struct packed {
        logic [NF-1:0][SEL_W-1:0] sel;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int f = 0; f < NF; f++) begin
            if (wr_en && (wr_fid == FID_W'(f))) begin
                st_d.sel[f] = wr_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;

    for (genvar g = 0; g < NF; g++) begin : g_iso
        AST_SEL_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_fid == FID_W'(g))) |=> $stable(sel_o[g])); // R5
    end

endmodule

// File: rtl/vq_queue_store.sv
module vq_queue_store
    import vq_cfg_pkg::*;
#(
    parameter int NF     = 4,
    parameter int NQ     = 8,
    parameter int FID_W  = 2,
    parameter int QIDX_W = 3,
    parameter int QMAX   = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [FID_W-1:0]    wr_fid,
    input  logic [QIDX_W-1:0]   wr_q,
    input  vq_reg_e             wr_reg,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [FID_W-1:0]    rd_fid,
    input  logic [QIDX_W-1:0]   rd_q,
    input  vq_reg_e             rd_reg,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int NENT  = NF * NQ;
    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;
    localparam vq_entry_t RST_ENTRY = '{desc: 64'h0, avail: 64'h0, size: 16'(QMAX), en: 1'b0};

    typedef struct packed {
        vq_entry_t [NENT-1:0] q;
    } store_t;

    store_t           st_d, st_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    vq_entry_t        rd_ent;

    assign wr_idx = IDX_W'(wr_fid) * IDX_W'(NQ) + IDX_W'(wr_q);
    assign rd_idx = IDX_W'(rd_fid) * IDX_W'(NQ) + IDX_W'(rd_q);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_reg)
                REG_DESC_LO:  st_d.q[wr_idx].desc[31:0]   = wr_data;
                REG_DESC_HI:  st_d.q[wr_idx].desc[63:32]  = wr_data;
                REG_AVAIL_LO: st_d.q[wr_idx].avail[31:0]  = wr_data;
                REG_AVAIL_HI: st_d.q[wr_idx].avail[63:32] = wr_data;
                REG_SIZE:     st_d.q[wr_idx].size         = wr_data[15:0];
                REG_ENABLE:   st_d.q[wr_idx].en           = wr_data[0];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                st_q.q[i] <= RST_ENTRY;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_ent  = st_q.q[rd_idx];
        rd_data = '0;
        case (rd_reg)
            REG_DESC_LO:  rd_data = rd_ent.desc[31:0];
            REG_DESC_HI:  rd_data = rd_ent.desc[63:32];
            REG_AVAIL_LO: rd_data = rd_ent.avail[31:0];
            REG_AVAIL_HI: rd_data = rd_ent.avail[63:32];
            REG_SIZE:     rd_data = {16'h0, rd_ent.size};
            REG_ENABLE:   rd_data = {31'h0, rd_ent.en};
            default:      rd_data = '0;
        endcase
    end

    for (genvar g = 0; g < NENT; g++) begin : g_keep
        AST_ENTRY_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == IDX_W'(g))) |=> $stable(st_q.q[g])); // R3
    end

endmodule

// File: rtl/vq_cfg_regs.sv
module vq_cfg_regs
    import vq_cfg_pkg::*;
#(
    parameter int NF    = 4,
    parameter int NQ    = 8,
    parameter int SEL_W = 8,
    parameter int QMAX  = 256,
    localparam int FID_W  = (NF > 1) ? $clog2(NF) : 1,
    localparam int QIDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [FID_W-1:0]   req_fid,
    input  logic               req_write,
    input  logic               req_sel_en,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic               req_fld_en,
    input  logic [2:0]         req_off,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [31:0]        rsp_rdata
);

    typedef struct packed {
        logic        vld;
        logic [31:0] data;
    } rsp_t;

    rsp_t                      st_d, st_q;
    logic [NF-1:0][SEL_W-1:0]  sel_all;
    logic [SEL_W-1:0]          cur_sel;
    logic [SEL_W-1:0]          eff_sel;
    logic                      in_range;
    logic                      accept;
    logic                      sel_wr;
    logic                      fld_wr;
    vq_reg_e                   reg_id;
    logic [31:0]               store_rd;
    logic [31:0]               rd_mux;

    assign reg_id    = vq_reg_e'(req_off);
    assign req_ready = !st_q.vld || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign cur_sel   = sel_all[req_fid];
    assign eff_sel   = req_sel_en ? req_sel : cur_sel;
    assign in_range  = (eff_sel < SEL_W'(NQ));
    assign sel_wr    = accept && req_sel_en;
    assign fld_wr    = accept && req_write && req_fld_en && in_range && (reg_id != REG_SEL);

    vq_sel_bank #(
        .NF    (NF),
        .SEL_W (SEL_W),
        .FID_W (FID_W)
    ) i_sel_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sel_wr),
        .wr_fid (req_fid),
        .wr_sel (req_sel),
        .sel_o  (sel_all)
    );

    vq_queue_store #(
        .NF     (NF),
        .NQ     (NQ),
        .FID_W  (FID_W),
        .QIDX_W (QIDX_W),
        .QMAX   (QMAX)
    ) i_queue_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fld_wr),
        .wr_fid  (req_fid),
        .wr_q    (eff_sel[QIDX_W-1:0]),
        .wr_reg  (reg_id),
        .wr_data (req_wdata),
        .rd_fid  (req_fid),
        .rd_q    (eff_sel[QIDX_W-1:0]),
        .rd_reg  (reg_id),
        .rd_data (store_rd)
    );

    always_comb begin
        if (reg_id == REG_SEL) begin
            rd_mux = 32'(eff_sel);
        end else if (in_range) begin
            rd_mux = store_rd;
        end else begin
            rd_mux = '0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (accept && !req_write) begin
            st_d.vld  = 1'b1;
            st_d.data = rd_mux;
        end else if (rsp_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_rdata = st_q.data;

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R9

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_write |=> rsp_valid); // R8

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write |=> !rsp_valid); // R8

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_write && !in_range && (req_off != 3'd0)
        |=> rsp_rdata == 32'h0); // R6

endmodule

// File: tb/test_vq_cfg_regs.sv
module test_vq_cfg_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NF    = 4;
    localparam int NQ    = 8;
    localparam int SEL_W = 8;
    localparam int QMAX  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_fid = '0;
    logic        req_write = 1'b0;
    logic        req_sel_en = 1'b0;
    logic [7:0]  req_sel = '0;
    logic        req_fld_en = 1'b0;
    logic [2:0]  req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_err = 0;
    int bp_mode = 0;
    bit done = 1'b0;
    bit pop_now = 1'b0;
    bit hold_prev = 1'b0;
    logic [31:0] prev_data;

    int unsigned m_sel [NF];
    logic [63:0] m_desc [NF][NQ];
    logic [63:0] m_avail [NF][NQ];
    logic [15:0] m_size [NF][NQ];
    logic        m_en [NF][NQ];
    logic [31:0] exp_q [$];
    string       exp_tag [$];

    vq_cfg_regs #(.NF(NF), .NQ(NQ), .SEL_W(SEL_W), .QMAX(QMAX)) i_vq_cfg_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_fid    (req_fid),
        .req_write  (req_write),
        .req_sel_en (req_sel_en),
        .req_sel    (req_sel),
        .req_fld_en (req_fld_en),
        .req_off    (req_off),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_rdata  (rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(int f, int off);
        int s = m_sel[f];
        if (off == 0) return 32'(s);
        if (s >= NQ) return 32'h0;
        case (off)
            1: return m_desc[f][s][31:0];
            2: return m_desc[f][s][63:32];
            3: return m_avail[f][s][31:0];
            4: return m_avail[f][s][63:32];
            5: return {16'h0, m_size[f][s]};
            6: return {31'h0, m_en[f][s]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_apply(int f, bit wr, bit se, int s, bit fe, int off, logic [31:0] d, string tag);
        int q;
        if (se) m_sel[f] = s % 256;
        q = m_sel[f];
        if (!wr) begin
            exp_q.push_back(model_read(f, off));
            exp_tag.push_back(tag);
        end else if (fe && q < NQ) begin
            case (off)
                1: m_desc[f][q][31:0]   = d;
                2: m_desc[f][q][63:32]  = d;
                3: m_avail[f][q][31:0]  = d;
                4: m_avail[f][q][63:32] = d;
                5: m_size[f][q]         = d[15:0];
                6: m_en[f][q]           = d[0];
                default: ;
            endcase
        end
    endtask

    // Entered just after a rising edge; returns just after the accepting edge.
    task automatic issue(int f, bit wr, bit se, int s, bit fe, int off, logic [31:0] d, string tag);
        req_fid    = 2'(f);
        req_write  = wr;
        req_sel_en = se;
        req_sel    = 8'(s);
        req_fld_en = fe;
        req_off    = 3'(off);
        req_wdata  = d;
        req_valid  = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        model_apply(f, wr, se, s, fe, off, d, tag);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic rd(int f, int off, string tag);
        issue(f, 1'b0, 1'b0, 0, 1'b0, off, 32'h0, tag);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Per-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rsp_valid == (exp_q.size() != 0), "R8 rsp_valid", 32'(rsp_valid), 32'(exp_q.size() != 0));
            if (req_valid)
                chk(req_ready == !(rsp_valid && !rsp_ready), "R9 req_ready", 32'(req_ready),
                    32'(!(rsp_valid && !rsp_ready)));
            if (hold_prev && rsp_valid)
                chk(rsp_rdata == prev_data, "R9 held data", rsp_rdata, prev_data);
            hold_prev = rsp_valid && !rsp_ready;
            prev_data = rsp_rdata;
            if (rsp_valid && rsp_ready && exp_q.size() != 0) begin
                chk(rsp_rdata == exp_q[0], exp_tag[0], rsp_rdata, exp_q[0]);
                pop_now = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        if (pop_now) begin
            void'(exp_q.pop_front());
            void'(exp_tag.pop_front());
            pop_now = 1'b0;
        end
        #1;
        case (bp_mode)
            0: rsp_ready = 1'b1;
            1: rsp_ready = 1'($urandom_range(0, 1));
            default: rsp_ready = 1'b0;
        endcase
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < NF; f++) begin
            m_sel[f] = 0;
            for (int q = 0; q < NQ; q++) begin
                m_desc[f][q] = '0; m_avail[f][q] = '0; m_size[f][q] = 16'(QMAX); m_en[f][q] = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid reset", 32'(rsp_valid), 32'h0);
        chk(req_ready == 1'b1, "R1 req_ready reset", 32'(req_ready), 32'h1);
        @(posedge clk); #1;

        // R1: reset values
        for (int f = 0; f < NF; f++) rd(f, 0, "R1 selector reset");
        for (int q = 0; q < NQ; q += 3) begin
            issue(2, 1'b0, 1'b1, q, 1'b0, 5, 0, "R1 size reset");
            rd(2, 1, "R1 desc reset"); rd(2, 4, "R1 avail reset"); rd(2, 6, "R1 enable reset");
        end

        // R2 + R4: combined write, then back-to-back read through latched selector
        issue(1, 1'b1, 1'b1, 3, 1'b1, 1, 32'h1111_2222, "R2");
        rd(1, 1, "R2 R4 combined write readback");
        issue(1, 1'b1, 1'b1, 3, 1'b1, 4, 32'hA5A5_0001, "R2");
        rd(1, 4, "R2 avail hi");

        // R3: selector-only write leaves fields alone
        issue(1, 1'b1, 1'b1, 5, 1'b0, 1, 32'hDEAD_BEEF, "R3");
        rd(1, 1, "R3 other queue untouched");
        rd(1, 0, "R3 selector stored");
        issue(1, 1'b1, 1'b1, 3, 1'b0, 1, 32'hFFFF_FFFF, "R3");
        rd(1, 1, "R3 field unchanged");

        // R5: interleaved functions
        issue(0, 1'b1, 1'b1, 2, 1'b0, 0, 0, "R5");
        issue(2, 1'b1, 1'b1, 6, 1'b1, 2, 32'h0BAD_F00D, "R5");
        issue(3, 1'b1, 1'b1, 7, 1'b0, 0, 0, "R5");
        rd(0, 0, "R5 selector isolated");
        rd(0, 2, "R5 field of own queue");
        rd(2, 2, "R5 other function field");

        // R6: out-of-range selector
        issue(3, 1'b1, 1'b1, 9, 1'b1, 1, 32'h7777_7777, "R6");
        rd(3, 1, "R6 oor field read zero");
        rd(3, 0, "R6 oor selector readback");
        issue(3, 1'b1, 1'b0, 0, 1'b1, 5, 32'h0000_0010, "R6");
        for (int q = 0; q < NQ; q++) begin
            issue(3, 1'b0, 1'b1, q, 1'b0, 1, 0, "R6 no queue written");
            rd(3, 5, "R6 size untouched");
        end
        issue(3, 1'b1, 1'b1, 255, 1'b1, 6, 32'h1, "R6");
        rd(3, 6, "R6 max selector read zero");
        rd(3, 0, "R6 selector 255");

        // R7: field widths and reserved word
        issue(0, 1'b1, 1'b1, 1, 1'b1, 5, 32'hABCD_1234, "R7");
        rd(0, 5, "R7 size low half");
        issue(0, 1'b1, 1'b0, 0, 1'b1, 6, 32'hFFFF_FFFE, "R7");
        rd(0, 6, "R7 enable bit0 clear");
        issue(0, 1'b1, 1'b0, 0, 1'b1, 6, 32'h0000_0003, "R7");
        rd(0, 6, "R7 enable bit0 set");
        issue(0, 1'b1, 1'b0, 0, 1'b1, 7, 32'h1234_5678, "R7");
        rd(0, 7, "R7 reserved reads zero");
        issue(0, 1'b1, 1'b0, 0, 1'b1, 0, 32'h0000_0004, "R7");
        rd(0, 0, "R7 field write to selector word ignored");

        // R10: read carrying a selector
        issue(2, 1'b0, 1'b1, 6, 1'b0, 2, 0, "R10 read with selector");
        issue(2, 1'b0, 1'b1, 3, 1'b0, 5, 0, "R10 read with selector");
        rd(2, 0, "R10 selector latched by read");

        // R8: back-to-back mixed burst
        for (int i = 0; i < 24; i++)
            issue(i % NF, i[0], 1'b0, 0, 1'b1, 1 + (i % 6), 32'(i * 32'h0101_0101), "R8 burst");
        drain();

        // R9: held backpressure with a queued read
        bp_mode = 2;
        @(posedge clk); #1;
        rd(1, 1, "R9 first read order");
        fork
            rd(2, 2, "R9 second read order");
            begin
                repeat (6) @(posedge clk);
                bp_mode = 0;
            end
        join
        drain();

        // Mixed traffic with random backpressure
        bp_mode = 1;
        for (int i = 0; i < 400; i++) begin
            int f   = $urandom_range(0, NF - 1);
            bit wr  = 1'($urandom_range(0, 1));
            bit se  = ($urandom_range(0, 3) == 0);
            int s   = $urandom_range(0, 11);
            bit fe  = 1'($urandom_range(0, 1));
            int off = $urandom_range(0, 7);
            issue(f, wr, se, s, fe, off, $urandom, "R4 mixed traffic");
        end
        bp_mode = 0;
        drain();
        repeat (2) @(posedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule